// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Unit

This block holds the control registers of a set of DMA channels. Each channel has its own register window. A host reads and writes 32-bit words through a single request port, and the response comes back one cycle later. Each channel keeps a three-state lifecycle (reset, stopped, running). It keeps pointers into a descriptor list and an interrupt mask. It also keeps a raw interrupt vector, which the data engine sets and the host acknowledges.

The unit does not move any data. It tells the data engine what to do with single-cycle pulses: load a descriptor, load a context and start the channel. It reads the descriptor and context fields it needs through a zero-latency fetch port, addressed by its own pointer registers.

Writing the command register asks a parked channel to continue. The unit re-reads the descriptor the channel stopped on. The channel moves on to the next descriptor only when software has cleared that descriptor's end-of-list bit since the channel parked.

Top module: `dmac_ctrl_unit`

## Requirements
- R1: After reset, every channel's status word reads 0x101 (reset state, stream-source bit 8 set). Every other register reads 0 and all interrupt lines are low.
- R2: The channel index is address bit 13 upward. The word offset is address bits [7:2], and bits [12:8] and [1:0] must be zero. The offsets are: data pointer 0x00, saved data 0x58, saved buffer 0x5C, group 0x60, group-down 0x7C, command 0x80, config 0x84, status 0x88, mask 0x8C, acknowledge 0x90, raw 0x94, masked 0x98, stream command 0x9C. Any other offset or address reads 0 and ignores writes.
- R3: A request whose size code is not 2 (0 = byte, 1 = halfword, 2 = word) gets an error response with read data 0, and it changes no register.
- R4: A config write with bit 1 set forces the stopped state (2). A config write with bit 0 clear forces the reset state (1), and reset wins when both apply. Status bits [2:0] hold the state, bit 5 holds the channel's end-of-list flag and bit 8 is 1.
- R5: A stream-command write uses only bits [9:0]. If any bit of 0x140 is set, the unit pulses descriptor load, copies saved data into the data pointer and caches the fetched end-of-list bit. If bit 0x20 is also set, the channel becomes running (4), its end-of-list flag clears and the start pulse fires.
- R6: A stream command with bit 0x200 set pulses context load and copies the context's two fetched fields into saved data and saved buffer. A descriptor load in the same write uses the old saved data.
- R7: A command write attempts a continue only if config bit 0 is 1, config bit 1 is 0, the state is running and the cached descriptor end-of-list bit is set. Otherwise nothing except the command register changes.
- R8: An attempted continue re-reads the descriptor at saved data: it pulses descriptor load and loads the saved buffer from the descriptor's buffer field. If the re-read end-of-list bit is clear while the channel flag is set, saved data takes the next field. One cycle later, that descriptor is loaded (data pointer, saved buffer and a second load pulse), the state becomes running, the flag clears and start pulses.
- R9: The engine's per-channel interrupt inputs OR into the raw vector. A write to acknowledge clears the written bits, and a new set in the same cycle wins. The acknowledge register reads 0.
- R10: The masked word equals raw AND mask, and a channel's interrupt line is high exactly when its masked word is nonzero.
- R11: An end-of-list input pulse sets the channel's status bit 5. When a start happens in the same cycle, the set wins.
- R12: Every request gives exactly one response, valid on the cycle after it, with read data taken before that request's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code, 2 = word |
| bus_addr | input | ADDR_W | Byte address, channel in the top bits |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Narrow-access error |
| desc_addr | output | 32 | Descriptor fetch address |
| ctx_addr | output | 32 | Context fetch address |
| desc_eol | input | 1 | Fetched descriptor end-of-list bit |
| desc_next | input | 32 | Fetched descriptor next pointer |
| desc_buf | input | 32 | Fetched descriptor buffer pointer |
| ctx_saved_data | input | 32 | Fetched context saved-data field |
| ctx_saved_buf | input | 32 | Fetched context saved-buffer field |
| eng_eol | input | NUM_CH | Engine reached end of list, per channel |
| eng_intr | input | NUM_CH*INTR_W | Engine interrupt set pulses, per channel |
| desc_load | output | NUM_CH | Descriptor load pulse |
| ctx_load | output | NUM_CH | Context load pulse |
| chan_start | output | NUM_CH | Channel start pulse |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
The continue path is tried with three patterns:
- The parked descriptor still carries its end-of-list bit. Here the unit reloads but must not advance or start.
- The bit has been cleared. Here the two-cycle advance and restart must appear.
- The channel is in the reset state. Here the command write must do nothing but store.

Stream commands are tried as a context load alone, a load with burst, a load without burst on the other channel, and a word with only bits above bit 9 set. These tell apart the individual bit tests and show that the high bits are masked. The interrupt path is driven with a set followed first by a mask change and then by a partial acknowledge. This separates the raw, masked and line outputs. Narrow accesses and the unmapped offsets confirm that state does not change.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    CH_RST  = 3'd1,
    CH_STOP = 3'd2,
    CH_RUN  = 3'd4
  } ch_state_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [5:0] OFF_DPTR  = 6'h00;
  localparam logic [5:0] OFF_SDATA = 6'h16;
  localparam logic [5:0] OFF_SBUF  = 6'h17;
  localparam logic [5:0] OFF_GRP   = 6'h18;
  localparam logic [5:0] OFF_GDN   = 6'h1F;
  localparam logic [5:0] OFF_CMD   = 6'h20;
  localparam logic [5:0] OFF_CFG   = 6'h21;
  localparam logic [5:0] OFF_STAT  = 6'h22;
  localparam logic [5:0] OFF_MASK  = 6'h23;
  localparam logic [5:0] OFF_ACK   = 6'h24;
  localparam logic [5:0] OFF_RAW   = 6'h25;
  localparam logic [5:0] OFF_MSKD  = 6'h26;
  localparam logic [5:0] OFF_SCMD  = 6'h27;

  localparam logic [9:0] SC_LOAD_D = 10'h140;
  localparam logic [9:0] SC_BURST  = 10'h020;
  localparam logic [9:0] SC_LOAD_C = 10'h200;

  function automatic logic sc_wants_desc(input logic [9:0] v);
    return |(v & SC_LOAD_D);
  endfunction

  function automatic logic sc_wants_start(input logic [9:0] v);
    return sc_wants_desc(v) && |(v & SC_BURST);
  endfunction

  function automatic logic sc_wants_ctx(input logic [9:0] v);
    return |(v & SC_LOAD_C);
  endfunction

  function automatic logic [31:0] stat_word(input ch_state_e s, input logic eol);
    return {23'd0, 1'b1, 2'd0, eol, 2'd0, s};
  endfunction

  function automatic logic may_continue(input logic en, input logic stop,
                                        input ch_state_e s, input logic cur_eol);
    return en && !stop && (s == CH_RUN) && cur_eol;
  endfunction

endpackage

// File: rtl/dmac_host_dec.sv
module dmac_host_dec import dmac_pkg::*; #(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = 13 + CH_W
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [CH_W-1:0]   dec_ch,
  output logic [5:0]        dec_off,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              acc_err
);
  logic is_word;
  logic in_map;

  assign dec_ch  = bus_addr[13 +: CH_W];
  assign dec_off = bus_addr[7:2];
  assign is_word = (bus_size == SZ_WORD);
  assign in_map  = (bus_addr[12:8] == 5'd0) && (bus_addr[1:0] == 2'd0) &&
                   (int'(dec_ch) < NUM_CH);
  assign acc_err = bus_valid && !is_word;
  assign wr_hit  = bus_valid && is_word && in_map && bus_write;
  assign rd_hit  = bus_valid && is_word && in_map && !bus_write;
endmodule

// File: rtl/dmac_irq.sv
module dmac_irq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         ack_en_i,
  input  logic [W-1:0] ack_bits_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] clr_bits;

  assign clr_bits = ack_en_i ? ack_bits_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= (raw_o & ~clr_bits) | set_i;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en_i |=> ((raw_o & $past(ack_bits_i & ~set_i)) == '0));

  assert_set_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & mask_i) != '0) |=> (irq_o || (mask_i != $past(mask_i))));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan import dmac_pkg::*; #(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        wr_off,
  input  logic [31:0]       wr_data,
  input  logic [5:0]        rd_off,
  output logic [31:0]       rd_data,
  input  logic              desc_eol_i,
  input  logic [31:0]       desc_next_i,
  input  logic [31:0]       desc_buf_i,
  input  logic [31:0]       ctx_data_i,
  input  logic [31:0]       ctx_buf_i,
  input  logic              eng_eol_i,
  input  logic [INTR_W-1:0] eng_intr_i,
  output logic [31:0]       sdata_o,
  output logic [31:0]       gdn_o,
  output logic              pend_o,
  output logic              desc_load_o,
  output logic              ctx_load_o,
  output logic              start_o,
  output logic              irq_o
);
  logic [31:0]       dptr, sbuf, grp, cmd, cfg, scmd;
  logic [INTR_W-1:0] mask, raw, masked;
  ch_state_e         state;
  logic              chan_eol, cur_eol;

  // named internal events
  logic wr_cfg, wr_cmd, wr_scmd, wr_ack;
  logic sc_d, sc_go, sc_c, cont_go, cont_adv;

  assign wr_cfg   = wr_en && (wr_off == OFF_CFG);
  assign wr_cmd   = wr_en && (wr_off == OFF_CMD);
  assign wr_scmd  = wr_en && (wr_off == OFF_SCMD);
  assign wr_ack   = wr_en && (wr_off == OFF_ACK);
  assign sc_d     = wr_scmd && sc_wants_desc(wr_data[9:0]);
  assign sc_go    = wr_scmd && sc_wants_start(wr_data[9:0]);
  assign sc_c     = wr_scmd && sc_wants_ctx(wr_data[9:0]);
  assign cont_go  = wr_cmd && may_continue(cfg[0], cfg[1], state, cur_eol);
  assign cont_adv = cont_go && !desc_eol_i && chan_eol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dptr <= '0; sdata_o <= '0; sbuf <= '0; grp <= '0; gdn_o <= '0;
      cmd <= '0; cfg <= '0; scmd <= '0; mask <= '0;
      state <= CH_RST; chan_eol <= 1'b0; cur_eol <= 1'b0; pend_o <= 1'b0;
      desc_load_o <= 1'b0; ctx_load_o <= 1'b0; start_o <= 1'b0;
    end else begin
      desc_load_o <= 1'b0;
      ctx_load_o  <= 1'b0;
      start_o     <= 1'b0;
      if (wr_en) begin
        case (wr_off)
          OFF_DPTR:  dptr    <= wr_data;
          OFF_SDATA: sdata_o <= wr_data;
          OFF_SBUF:  sbuf    <= wr_data;
          OFF_GRP:   grp     <= wr_data;
          OFF_GDN:   gdn_o   <= wr_data;
          OFF_CMD:   cmd     <= wr_data;
          OFF_CFG:   cfg     <= wr_data;
          OFF_SCMD:  scmd    <= wr_data;
          OFF_MASK:  mask    <= wr_data[INTR_W-1:0];
          default: ;
        endcase
      end
      if (wr_cfg) begin
        if (wr_data[1])  state <= CH_STOP;
        if (!wr_data[0]) state <= CH_RST;
      end
      if (sc_d) begin
        desc_load_o <= 1'b1;
        dptr        <= sdata_o;
        cur_eol     <= desc_eol_i;
      end
      if (sc_go) begin
        state    <= CH_RUN;
        chan_eol <= 1'b0;
        start_o  <= 1'b1;
      end
      if (sc_c) begin
        ctx_load_o <= 1'b1;
        sdata_o    <= ctx_data_i;
        sbuf       <= ctx_buf_i;
      end
      if (cont_go) begin
        desc_load_o <= 1'b1;
        dptr        <= sdata_o;
        cur_eol     <= desc_eol_i;
        sbuf        <= desc_buf_i;
        if (cont_adv) begin
          sdata_o <= desc_next_i;
          pend_o  <= 1'b1;
        end
      end
      if (pend_o) begin
        pend_o      <= 1'b0;
        desc_load_o <= 1'b1;
        dptr        <= sdata_o;
        cur_eol     <= desc_eol_i;
        sbuf        <= desc_buf_i;
        state       <= CH_RUN;
        chan_eol    <= 1'b0;
        start_o     <= 1'b1;
      end
      if (eng_eol_i) chan_eol <= 1'b1;
    end
  end

  dmac_irq #(.W(INTR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(eng_intr_i), .ack_en_i(wr_ack),
    .ack_bits_i(wr_data[INTR_W-1:0]), .mask_i(mask),
    .raw_o(raw), .masked_o(masked), .irq_o(irq_o)
  );

  always_comb begin
    case (rd_off)
      OFF_DPTR:  rd_data = dptr;
      OFF_SDATA: rd_data = sdata_o;
      OFF_SBUF:  rd_data = sbuf;
      OFF_GRP:   rd_data = grp;
      OFF_GDN:   rd_data = gdn_o;
      OFF_CMD:   rd_data = cmd;
      OFF_CFG:   rd_data = cfg;
      OFF_STAT:  rd_data = stat_word(state, chan_eol);
      OFF_MASK:  rd_data = 32'(mask);
      OFF_RAW:   rd_data = 32'(raw);
      OFF_MSKD:  rd_data = 32'(masked);
      OFF_SCMD:  rd_data = scmd;
      default:   rd_data = '0;
    endcase
  end

  assert_cfg_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !wr_data[0] && !pend_o) |=> (state == CH_RST));

  assert_ctx_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load_o |-> (sdata_o == $past(ctx_data_i) && sbuf == $past(ctx_buf_i)));

  assert_advance_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cont_adv |=> (pend_o && sdata_o == $past(desc_next_i)));

  assert_pend_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |=> (start_o && desc_load_o && state == CH_RUN));

  assert_no_cont_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !cont_go && !pend_o) |=> !start_o);
endmodule

// File: rtl/dmac_ctrl_unit.sv
module dmac_ctrl_unit import dmac_pkg::*; #(
  parameter int NUM_CH = 2,
  parameter int INTR_W = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = 13 + CH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [1:0]               bus_size,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_err,
  output logic [31:0]              desc_addr,
  output logic [31:0]              ctx_addr,
  input  logic                     desc_eol,
  input  logic [31:0]              desc_next,
  input  logic [31:0]              desc_buf,
  input  logic [31:0]              ctx_saved_data,
  input  logic [31:0]              ctx_saved_buf,
  input  logic [NUM_CH-1:0]        eng_eol,
  input  logic [NUM_CH*INTR_W-1:0] eng_intr,
  output logic [NUM_CH-1:0]        desc_load,
  output logic [NUM_CH-1:0]        ctx_load,
  output logic [NUM_CH-1:0]        chan_start,
  output logic [NUM_CH-1:0]        irq
);
  logic [CH_W-1:0] dec_ch;
  logic [5:0]      dec_off;
  logic            wr_hit, rd_hit, acc_err;

  dmac_host_dec #(.NUM_CH(NUM_CH)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .dec_ch(dec_ch), .dec_off(dec_off),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .acc_err(acc_err)
  );

  logic [31:0]       rd_arr [NUM_CH];
  logic [31:0]       sd_arr [NUM_CH];
  logic [31:0]       gd_arr [NUM_CH];
  logic [NUM_CH-1:0] pend_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_this;
    assign wr_this = wr_hit && (int'(dec_ch) == c);
    dmac_chan #(.INTR_W(INTR_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_this), .wr_off(dec_off),
      .wr_data(bus_wdata), .rd_off(dec_off), .rd_data(rd_arr[c]),
      .desc_eol_i(desc_eol), .desc_next_i(desc_next), .desc_buf_i(desc_buf),
      .ctx_data_i(ctx_saved_data), .ctx_buf_i(ctx_saved_buf),
      .eng_eol_i(eng_eol[c]), .eng_intr_i(eng_intr[c*INTR_W +: INTR_W]),
      .sdata_o(sd_arr[c]), .gdn_o(gd_arr[c]), .pend_o(pend_vec[c]),
      .desc_load_o(desc_load[c]), .ctx_load_o(ctx_load[c]),
      .start_o(chan_start[c]), .irq_o(irq[c])
    );
  end

  // a pending continue owns the fetch port for its second cycle
  logic            pend_any;
  logic [CH_W-1:0] pend_idx;
  logic [CH_W-1:0] fetch_ch;

  always_comb begin
    pend_any = 1'b0;
    pend_idx = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (pend_vec[c]) begin
        pend_any = 1'b1;
        pend_idx = CH_W'(c);
      end
    end
  end

  assign fetch_ch  = pend_any ? pend_idx : dec_ch;
  assign desc_addr = sd_arr[fetch_ch];
  assign ctx_addr  = gd_arr[fetch_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= rd_hit ? rd_arr[dec_ch] : '0;
    end
  end

  assert_narrow_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != SZ_WORD) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  assert_one_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid);

  assert_single_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_vec) <= 1);
endmodule

// File: tb/sim_dmac_ctrl_unit.sv
`timescale 1ns/1ps
module sim_dmac_ctrl_unit;
  localparam int NCH = 2;
  localparam int IW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_size = 2'd2;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, desc_addr, ctx_addr;
  logic desc_eol;
  logic [31:0] desc_next, desc_buf, ctx_sd, ctx_sb;
  logic [NCH-1:0] eng_eol = '0;
  logic [NCH*IW-1:0] eng_intr = '0;
  logic [NCH-1:0] desc_load, ctx_load, chan_start, irq;

  always #4 clk = ~clk;

  dmac_ctrl_unit #(.NUM_CH(NCH), .INTR_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .desc_addr(desc_addr), .ctx_addr(ctx_addr), .desc_eol(desc_eol),
    .desc_next(desc_next), .desc_buf(desc_buf), .ctx_saved_data(ctx_sd),
    .ctx_saved_buf(ctx_sb), .eng_eol(eng_eol), .eng_intr(eng_intr),
    .desc_load(desc_load), .ctx_load(ctx_load), .chan_start(chan_start), .irq(irq)
  );

  // descriptor / context memory
  logic        mem_eol [logic [31:0]];
  logic [31:0] mem_nx  [logic [31:0]];
  logic [31:0] mem_bf  [logic [31:0]];
  logic [31:0] mem_csd [logic [31:0]];
  logic [31:0] mem_csb [logic [31:0]];
  int mem_gen = 0;

  function automatic logic f_eol(input logic [31:0] a);
    return mem_eol.exists(a) ? mem_eol[a] : 1'b0;
  endfunction
  function automatic logic [31:0] f_nx(input logic [31:0] a);
    return mem_nx.exists(a) ? mem_nx[a] : 32'd0;
  endfunction
  function automatic logic [31:0] f_bf(input logic [31:0] a);
    return mem_bf.exists(a) ? mem_bf[a] : 32'd0;
  endfunction
  function automatic logic [31:0] f_csd(input logic [31:0] a);
    return mem_csd.exists(a) ? mem_csd[a] : 32'd0;
  endfunction
  function automatic logic [31:0] f_csb(input logic [31:0] a);
    return mem_csb.exists(a) ? mem_csb[a] : 32'd0;
  endfunction

  always @(desc_addr, ctx_addr, mem_gen) begin
    desc_eol  = f_eol(desc_addr);
    desc_next = f_nx(desc_addr);
    desc_buf  = f_bf(desc_addr);
    ctx_sd    = f_csd(ctx_addr);
    ctx_sb    = f_csb(ctx_addr);
  end

  // behavioural reference model
  logic [31:0] m_dp[NCH], m_sd[NCH], m_sb[NCH], m_gp[NCH], m_gd[NCH];
  logic [31:0] m_cmd[NCH], m_cfg[NCH], m_sc[NCH];
  logic [3:0]  m_mask[NCH], m_raw[NCH];
  int          m_st[NCH];
  bit          m_ceol[NCH], m_cur[NCH], m_pend[NCH];
  bit          e_rv, e_err;
  logic [31:0] e_rd;
  logic [NCH-1:0] e_dl, e_cl, e_st;

  function automatic logic [31:0] mread(input int c, input int o);
    case (o)
      'h00: return m_dp[c];   'h16: return m_sd[c];  'h17: return m_sb[c];
      'h18: return m_gp[c];   'h1F: return m_gd[c];  'h20: return m_cmd[c];
      'h21: return m_cfg[c];  'h23: return 32'(m_mask[c]);
      'h22: return 32'(m_st[c]) | (32'(m_ceol[c]) << 5) | 32'h100;
      'h25: return 32'(m_raw[c]); 'h26: return 32'(m_raw[c] & m_mask[c]);
      'h27: return m_sc[c];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_dp[c] = 0; m_sd[c] = 0; m_sb[c] = 0; m_gp[c] = 0; m_gd[c] = 0;
        m_cmd[c] = 0; m_cfg[c] = 0; m_sc[c] = 0; m_mask[c] = 0; m_raw[c] = 0;
        m_st[c] = 1; m_ceol[c] = 0; m_cur[c] = 0; m_pend[c] = 0;
      end
      e_rv = 0; e_err = 0; e_rd = 0; e_dl = 0; e_cl = 0; e_st = 0;
    end else begin
      logic [3:0] ackv[NCH];
      e_dl = 0; e_cl = 0; e_st = 0;
      for (int c = 0; c < NCH; c++) begin
        ackv[c] = 0;
        if (m_pend[c]) begin
          m_pend[c] = 0; e_dl[c] = 1; e_st[c] = 1;
          m_dp[c] = m_sd[c]; m_cur[c] = f_eol(m_sd[c]); m_sb[c] = f_bf(m_sd[c]);
          m_st[c] = 4; m_ceol[c] = 0;
        end
      end
      e_rv = bus_valid; e_err = bus_valid && bus_size != 2; e_rd = 0;
      if (bus_valid && bus_size == 2 && bus_addr[12:8] == 0 && bus_addr[1:0] == 0) begin
        int c, o;
        logic [31:0] v, a;
        c = int'(bus_addr[13]); o = int'(bus_addr[7:2]); v = bus_wdata;
        if (!bus_write) e_rd = mread(c, o);
        else begin
          case (o)
            'h00: m_dp[c] = v;  'h16: m_sd[c] = v; 'h17: m_sb[c] = v;
            'h18: m_gp[c] = v;  'h1F: m_gd[c] = v;
            'h23: m_mask[c] = v[3:0];
            'h24: ackv[c] = v[3:0];
            'h21: begin
              m_cfg[c] = v;
              if (v[1]) m_st[c] = 2;
              if (!v[0]) m_st[c] = 1;
            end
            'h20: begin
              m_cmd[c] = v;
              if (m_cfg[c][0] && !m_cfg[c][1] && m_st[c] == 4 && m_cur[c]) begin
                a = m_sd[c]; e_dl[c] = 1; m_dp[c] = a; m_sb[c] = f_bf(a);
                if (!f_eol(a) && m_ceol[c]) begin m_sd[c] = f_nx(a); m_pend[c] = 1; end
                m_cur[c] = f_eol(a);
              end
            end
            'h27: begin
              m_sc[c] = v; a = m_sd[c];
              if ((v & 32'h140) != 0) begin
                e_dl[c] = 1; m_dp[c] = a; m_cur[c] = f_eol(a);
                if ((v & 32'h20) != 0) begin m_st[c] = 4; m_ceol[c] = 0; e_st[c] = 1; end
              end
              if ((v & 32'h200) != 0) begin
                e_cl[c] = 1; m_sd[c] = f_csd(m_gd[c]); m_sb[c] = f_csb(m_gd[c]);
              end
            end
            default: ;
          endcase
        end
      end
      for (int c = 0; c < NCH; c++) begin
        m_raw[c] = (m_raw[c] & ~ackv[c]) | eng_intr[c*IW +: IW];
        if (eng_eol[c]) m_ceol[c] = 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 rsp_valid", 32'(rsp_valid), 32'(e_rv));
      chk("R3 rsp_err", 32'(rsp_err), 32'(e_err));
      if (e_rv) chk("R12 rsp_rdata", rsp_rdata, e_rd);
      chk("R5 desc_load", 32'(desc_load), 32'(e_dl));
      chk("R6 ctx_load", 32'(ctx_load), 32'(e_cl));
      chk("R8 chan_start", 32'(chan_start), 32'(e_st));
      for (int c = 0; c < NCH; c++)
        chk("R10 irq", 32'(irq[c]), 32'(|(m_raw[c] & m_mask[c])));
    end
  end

  task automatic bus_op(input bit w, input logic [1:0] sz, input logic [13:0] a,
                        input logic [31:0] d);
    @(posedge clk); #2;
    bus_valid = 1; bus_write = w; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_valid = 0; bus_write = 0; bus_size = 2;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    bus_op(1, 2, a, d);
  endtask

  task automatic rd_expect(input string req, input logic [13:0] a, input logic [31:0] exp);
    bus_op(0, 2, a, 0);
    @(negedge clk); #1;
    chk(req, 32'(rsp_valid), 32'd1);
    chk(req, rsp_rdata, exp);
  endtask

  task automatic eng_pulse(input logic [NCH-1:0] eo, input logic [NCH*IW-1:0] ei);
    @(posedge clk); #2; eng_eol = eo; eng_intr = ei;
    @(posedge clk); #2; eng_eol = 0; eng_intr = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mem_csd[32'h400] = 32'h1000; mem_csb[32'h400] = 32'h1100;
    mem_eol[32'h1000] = 1; mem_nx[32'h1000] = 32'h1040; mem_bf[32'h1000] = 32'h2000;
    mem_eol[32'h1040] = 0; mem_nx[32'h1040] = 32'h1080; mem_bf[32'h1040] = 32'h3000;
    mem_gen++;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset values
    rd_expect("R1 stat ch0", 14'h0088, 32'h101);
    rd_expect("R1 stat ch1", 14'h2088, 32'h101);
    rd_expect("R1 mask", 14'h008C, 32'h0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 decode
    wr(14'h2060, 32'hA5A5_0000);
    rd_expect("R2 group ch1", 14'h2060, 32'hA5A5_0000);
    rd_expect("R2 group ch0", 14'h0060, 32'h0);
    rd_expect("R2 unmapped off", 14'h0040, 32'h0);
    rd_expect("R2 high window", 14'h1060, 32'h0);
    rd_expect("R9 ack reads zero", 14'h2090, 32'h0);

    // R3 narrow access
    bus_op(1, 2'd0, 14'h0084, 32'h3);
    @(negedge clk); #1; chk("R3 byte write err", 32'(rsp_err), 32'd1);
    rd_expect("R3 cfg unchanged", 14'h0084, 32'h0);
    bus_op(0, 2'd1, 14'h0088, 32'h0);
    @(negedge clk); #1; chk("R3 half read err", 32'(rsp_err), 32'd1);
    chk("R3 half read data", rsp_rdata, 32'h0);

    // R4 config
    wr(14'h0084, 32'h3);
    rd_expect("R4 stop", 14'h0088, 32'h102);
    wr(14'h0084, 32'h2);
    rd_expect("R4 reset wins", 14'h0088, 32'h101);
    wr(14'h0084, 32'h1);
    rd_expect("R4 enable keeps state", 14'h0088, 32'h101);

    // R6 context load
    wr(14'h007C, 32'h400);
    wr(14'h009C, 32'h200);
    rd_expect("R6 saved data", 14'h0058, 32'h1000);
    rd_expect("R6 saved buf", 14'h005C, 32'h1100);

    // R5 stream command load + burst, and load only on ch1
    wr(14'h009C, 32'h160);
    rd_expect("R5 running", 14'h0088, 32'h104);
    rd_expect("R5 data ptr", 14'h0000, 32'h1000);
    wr(14'h2058, 32'h1040);
    wr(14'h209C, 32'h100);
    rd_expect("R5 ch1 data ptr", 14'h2000, 32'h1040);
    rd_expect("R5 ch1 no start", 14'h2088, 32'h101);
    wr(14'h209C, 32'hFFFF_FC00);
    rd_expect("R5 high bits ignored", 14'h2088, 32'h101);

    // R11 end of list
    eng_pulse(2'b01, '0);
    rd_expect("R11 eol flag", 14'h0088, 32'h124);

    // R7 continue with eol still set: reload only; ch1 in reset: nothing
    wr(14'h0080, 32'h1);
    rd_expect("R7 no restart", 14'h0088, 32'h124);
    rd_expect("R8 buf from reload", 14'h005C, 32'h2000);
    wr(14'h2080, 32'h1);
    rd_expect("R7 ch1 untouched", 14'h205C, 32'h0);

    // R8 continue after software clears eol
    mem_eol[32'h1000] = 0; mem_gen++;
    wr(14'h0080, 32'h1);
    rd_expect("R8 advanced", 14'h0058, 32'h1040);
    rd_expect("R8 next buf", 14'h005C, 32'h3000);
    rd_expect("R8 restarted", 14'h0088, 32'h104);
    rd_expect("R8 data ptr", 14'h0000, 32'h1040);

    // R9 / R10 interrupts
    eng_pulse('0, 8'h05);
    rd_expect("R9 raw", 14'h0094, 32'h5);
    rd_expect("R10 masked zero", 14'h0098, 32'h0);
    chk("R10 irq low", 32'(irq), 32'd0);
    wr(14'h008C, 32'h4);
    @(negedge clk); chk("R10 irq high", 32'(irq), 32'd1);
    rd_expect("R10 masked", 14'h0098, 32'h4);
    wr(14'h0090, 32'h4);
    rd_expect("R9 raw after ack", 14'h0094, 32'h1);
    chk("R10 irq after ack", 32'(irq), 32'd0);
    rd_expect("R9 ack readback", 14'h0090, 32'h0);

    repeat (4) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule